// File: doc/BRIEF.md
# Display Transmitter Control-Register I2C Target

This block is the serial control port of a display transmitter. It watches a two-wire I2C bus on SCL and SDA and picks out START and STOP conditions. It recognises its own 7-bit address, acknowledges it, and then shifts data bytes in from the bus master or out to it. It pulls SDA low through an open-drain enable when it acknowledges or sends a zero bit.

Every write transaction begins with a byte that sets an internal register pointer. Any further bytes go to the register that the pointer selects. Reads return the selected register. The pointer steps forward after every byte moved in either direction, so a burst walks through consecutive register addresses.

The register set is small. One system-control register runs a request/grant handshake for the display-data-channel path. An identification register returns a fixed value. An interrupt-status register always reports an attached sink. The block drives a level output that is high while the display-data-channel pass-through is active. All other registers read as zero, and writes to them are discarded.

Top module: `xmit_ctrl_i2c_target`

## Requirements
- R1: The target acknowledges a 7-bit address equal to the `TGT_ADDR` parameter, and it acknowledges every data byte written to it. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: The first data byte after the address of a write transaction loads the register pointer. That byte is not written into any register.
- R3: The 8-bit register pointer increments by one after each data byte is read or written. It wraps from 0xFF to 0x00.
- R4: Writing a byte with bit 2 (request) and bit 1 (grant) both set to address 0x1A turns pass-through mode on, and `ddc_passthru_o` goes high.
- R5: Writing a byte to 0x1A with bit 2 set and bit 1 clear records a pending request and leaves pass-through mode unchanged. While a request is pending, a read of 0x1A returns 0x06.
- R6: Writing a byte to 0x1A with bit 2 clear removes both the pending request and pass-through mode. After that, reads of 0x1A return 0x00.
- R7: Address 0x1B always reads 0xB0.
- R8: Address 0x3D always reads 0x04. Every address other than 0x1A, 0x1B and 0x3D reads 0x00, and this includes 0x3C.
- R9: Writes to any address other than 0x1A are acknowledged and have no effect on any register or on `ddc_passthru_o`.
- R10: Data bytes are sent MSB first. When the master does not acknowledge a read byte, the target releases SDA and stays released until the next START.
- R11: Reset clears the pointer to 0x00, clears the pending pointer load, the request and pass-through mode, and releases SDA.
- R12: SDA falling while SCL is high is a START, and it restarts address reception in any state. SDA rising while SCL is high is a STOP, and it returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe_o | output | 1 | High to pull SDA low (open drain) |
| ddc_passthru_o | output | 1 | High while display-data-channel pass-through is active |

## Verification
Each bus level change reaches the byte engine through two synchronizer flops and one edge-detect flop. The engine acts on the following clock edge, so SDA changes and register updates appear about three system clocks after the SCL edge that causes them. `ddc_passthru_o` changes three cycles after the falling SCL edge that ends a write to 0x1A. The bench holds each SCL phase for eight clocks. It changes SDA four clocks into the low phase and samples SDA four clocks into the high phase, so every sample lands well after the due cycle and before the next edge. The mode output is read only after a STOP, by which time any update has settled.

// File: rtl/xctl_pkg.sv
package xctl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W) + 1;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t REG_SYSCTL    = 8'h1A;
  localparam byte_t REG_IDENT     = 8'h1B;
  localparam byte_t REG_IRQ_STAT  = 8'h3D;
  localparam byte_t IDENT_VALUE   = 8'hB0;
  localparam byte_t IRQ_STAT_VAL  = 8'h04;
  localparam byte_t SYSCTL_GRANTD = 8'h06;

  localparam int unsigned SC_GRANT_BIT = 1;
  localparam int unsigned SC_REQ_BIT   = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_WR_DATA,
    PH_WR_ACK,
    PH_RD_DATA,
    PH_RD_ACK,
    PH_RD_NEXT
  } phase_e;
endpackage

// File: rtl/xctl_bus_sync.sv
module xctl_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_s_o
);
  localparam int unsigned N_LINES = 2;
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [N_LINES-1:0] line_in;
  logic [N_LINES-1:0] line_s;
  logic [N_LINES-1:0] prev_q;

  assign line_in = {sda_i, scl_i};

  // one synchronizer chain per bus line, idle level high
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    if (STAGES > 1) begin : g_deep
      assign chain_d = {chain_q[STAGES-2:0], line_in[g]};
    end else begin : g_single
      assign chain_d = line_in[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= chain_d;
    end
    assign line_s[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= line_s;
  end

  logic scl_hi_both;
  assign scl_hi_both = line_s[IDX_SCL] & prev_q[IDX_SCL];

  assign scl_rise_o = line_s[IDX_SCL] & ~prev_q[IDX_SCL];
  assign scl_fall_o = ~line_s[IDX_SCL] & prev_q[IDX_SCL];
  assign start_o    = scl_hi_both & prev_q[IDX_SDA] & ~line_s[IDX_SDA];
  assign stop_o     = scl_hi_both & ~prev_q[IDX_SDA] & line_s[IDX_SDA];
  assign sda_s_o    = line_s[IDX_SDA];

  assert_start_stop_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  assert_no_edge_on_cond_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/xctl_byte_engine.sv
module xctl_byte_engine
  import xctl_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h3B
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  logic  sda_s_i,
  input  byte_t rd_data_i,
  output logic  sda_oe_o,
  output logic  begin_wr_o,
  output logic  wr_en_o,
  output byte_t wr_data_o,
  output logic  rd_en_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  byte_t            shreg_q, shreg_d;
  logic             rw_q, rw_d;
  logic             oe_q, oe_d;
  logic             begin_wr, wr_en, rd_en;

  always_comb begin
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    rw_d     = rw_q;
    oe_d     = oe_q;
    begin_wr = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    if (stop_i) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else if (start_i) begin
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else begin
      unique case (phase_q)
        PH_ADDR, PH_WR_DATA: begin
          if (scl_rise_i) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_s_i};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall_i && bitcnt_q == FULL_CNT) begin
            bitcnt_d = '0;
            if (phase_q == PH_WR_DATA) begin
              wr_en   = 1'b1;
              phase_d = PH_WR_ACK;
              oe_d    = 1'b1;
            end else if (shreg_q[BYTE_W-1:1] == TGT_ADDR) begin
              phase_d  = PH_ADDR_ACK;
              oe_d     = 1'b1;
              rw_d     = shreg_q[0];
              begin_wr = ~shreg_q[0];
            end else begin
              phase_d = PH_IDLE;
            end
          end
        end
        PH_WR_ACK: begin
          if (scl_fall_i) begin
            phase_d = PH_WR_DATA;
            oe_d    = 1'b0;
          end
        end
        PH_ADDR_ACK, PH_RD_NEXT: begin
          if (scl_fall_i) begin
            bitcnt_d = '0;
            if (phase_q == PH_RD_NEXT || rw_q) begin
              phase_d = PH_RD_DATA;
              shreg_d = rd_data_i;
              rd_en   = 1'b1;
              oe_d    = ~rd_data_i[BYTE_W-1];
            end else begin
              phase_d = PH_WR_DATA;
              oe_d    = 1'b0;
            end
          end
        end
        PH_RD_DATA: begin
          if (scl_fall_i) begin
            if (bitcnt_q == LAST_TX) begin
              phase_d = PH_RD_ACK;
              oe_d    = 1'b0;
            end else begin
              bitcnt_d = bitcnt_q + 1'b1;
              shreg_d  = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_d     = ~shreg_q[BYTE_W-2];
            end
          end
        end
        PH_RD_ACK: begin
          if (scl_rise_i) begin
            phase_d = sda_s_i ? PH_IDLE : PH_RD_NEXT;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          oe_d    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      rw_q     <= rw_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign begin_wr_o = begin_wr;
  assign wr_en_o    = wr_en;
  assign wr_data_o  = shreg_q;
  assign rd_en_o    = rd_en;

  assert_idle_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> !oe_q);
  assert_stop_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (phase_q == PH_IDLE) && !oe_q);
  assert_one_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_en, rd_en, begin_wr}) <= 1);
  assert_ack_driven_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ADDR_ACK || phase_q == PH_WR_ACK) |-> oe_q);
endmodule

// File: rtl/xctl_regs.sv
module xctl_regs
  import xctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  begin_wr_i,
  input  logic  wr_en_i,
  input  byte_t wr_data_i,
  input  logic  rd_en_i,
  output byte_t rd_data_o,
  output logic  ddc_mode_o
);
  byte_t ptr_q, ptr_d;
  logic  ptr_en;
  logic  pend_q, pend_d, pend_en;
  logic  req_q, req_d;
  logic  mode_q, mode_d;
  logic  ctl_en;

  always_comb begin
    ptr_d   = ptr_q + 1'b1;
    ptr_en  = rd_en_i | wr_en_i;
    pend_d  = pend_q;
    pend_en = 1'b0;
    ctl_en  = 1'b0;
    req_d   = req_q;
    mode_d  = mode_q;
    if (begin_wr_i) begin
      pend_d  = 1'b1;
      pend_en = 1'b1;
    end else if (wr_en_i && pend_q) begin
      ptr_d   = wr_data_i;
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end else if (wr_en_i && ptr_q == REG_SYSCTL) begin
      ctl_en = 1'b1;
      if (wr_data_i[SC_REQ_BIT]) begin
        req_d = 1'b1;
        if (wr_data_i[SC_GRANT_BIT]) mode_d = 1'b1;
      end else begin
        req_d  = 1'b0;
        mode_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (ctl_en) begin
      req_q  <= req_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    unique case (ptr_q)
      REG_SYSCTL:   rd_data_o = req_q ? SYSCTL_GRANTD : '0;
      REG_IDENT:    rd_data_o = IDENT_VALUE;
      REG_IRQ_STAT: rd_data_o = IRQ_STAT_VAL;
      default:      rd_data_o = '0;
    endcase
  end

  assign ddc_mode_o = mode_q;

  assert_mode_needs_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> req_q);
  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> ptr_q == $past(ptr_q) + 8'd1);
  assert_ptr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pend_q) |=> (ptr_q == $past(wr_data_i)) && !pend_q && $stable(mode_q));
  assert_enter_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pend_q && ptr_q == REG_SYSCTL && wr_data_i[SC_REQ_BIT] && wr_data_i[SC_GRANT_BIT])
      |=> mode_q);
  assert_req_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pend_q && ptr_q == REG_SYSCTL && wr_data_i[SC_REQ_BIT] && !wr_data_i[SC_GRANT_BIT])
      |=> req_q && (mode_q == $past(mode_q)));
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pend_q && ptr_q == REG_SYSCTL && !wr_data_i[SC_REQ_BIT]) |=> !req_q && !mode_q);
  assert_other_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pend_q && ptr_q != REG_SYSCTL) |=> $stable(req_q) && $stable(mode_q));
endmodule

// File: rtl/xmit_ctrl_i2c_target.sv
module xmit_ctrl_i2c_target
  import xctl_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h3B,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic ddc_passthru_o
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[RST_STAGES-1];

  logic  scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic  begin_wr, wr_en, rd_en;
  byte_t wr_data, rd_data;

  xctl_bus_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .sda_s_o    (sda_s)
  );

  xctl_byte_engine #(
    .TGT_ADDR (TGT_ADDR)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_s_i    (sda_s),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .begin_wr_o (begin_wr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .rd_en_o    (rd_en)
  );

  xctl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .begin_wr_i (begin_wr),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .ddc_mode_o (ddc_passthru_o)
  );

  assert_reset_released_R11: assert property (@(posedge clk_i)
    !rst_n |=> !sda_oe_o && !ddc_passthru_o);
endmodule

// File: tb/test_xmit_ctrl_i2c_target.sv
module test_xmit_ctrl_i2c_target;
  localparam logic [6:0] TGT = 7'h3B;
  localparam logic [7:0] AW  = {TGT, 1'b0};
  localparam logic [7:0] AR  = {TGT, 1'b1};
  localparam int         Q   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m;
  logic sda_oe, ddc;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  xmit_ctrl_i2c_target #(.TGT_ADDR(TGT)) i_xmit_ctrl_i2c_target (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scl_i          (scl_m),
    .sda_i          (sda_bus),
    .sda_oe_o       (sda_oe),
    .ddc_passthru_o (ddc)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic v);
    wq(1); sda_m = b;
    wq(1); scl_m = 1'b1;
    wq(1); v = sda_bus;
    wq(1); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(1); sda_m = 1'b0;
    wq(1); scl_m = 1'b1;
    wq(1); sda_m = 1'b1;
    wq(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) xfer_bit(d[i], v);
    xfer_bit(1'b1, v);
    ack = ~v;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, v);
      d[i] = v;
    end
    xfer_bit(~give_ack, v);
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] p, input bit req);
    case (p)
      8'h1A:   return req ? 8'h06 : 8'h00;
      8'h1B:   return 8'hB0;
      8'h3D:   return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] p);
    if (p == 8'h1B) return "R7";
    if (p == 8'h1A) return "R5";
    return "R8";
  endfunction

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d, input string req);
    logic a;
    bus_start();
    send_byte(AW, a); check({req, " addr ack"}, a, 1);
    send_byte(p, a);  check({req, " ptr ack"}, a, 1);
    send_byte(d, a);  check({req, " data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(AW, a); check("R12 addr ack", a, 1);
    send_byte(p, a);  check("R2 ptr ack", a, 1);
    bus_start();
    send_byte(AR, a); check("R12 restart ack", a, 1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    logic a, v;
    logic [7:0] d;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R11 sda released", sda_oe, 0);
    check("R11 mode off", ddc, 0);

    // R11/R3/R7/R8: read sweep from the reset pointer, wrapping once
    bus_start();
    send_byte(AR, a); check("R1 read addr ack", a, 1);
    for (int i = 0; i <= 256; i++) begin
      recv_byte(i != 256, d);
      check((i == 256) ? "R3 wrap" : tag_of(8'(i)), d, exp_reg(8'(i), 1'b0));
    end
    bus_stop();
    check("R10 released after nack", sda_oe, 0);

    // R1: foreign address is not acknowledged and the target stays off the bus
    bus_start();
    send_byte({7'h3A, 1'b0}, a); check("R1 foreign addr", a, 0);
    send_byte(8'h00, a);         check("R1 foreign data", a, 0);
    bus_stop();

    // R12: STOP in the middle of an address byte, then a normal access
    bus_start();
    for (int i = 0; i < 4; i++) xfer_bit(AW[7-i], v);
    bus_stop();
    check("R12 idle after stop", sda_oe, 0);
    read_reg(8'h1B, d); check("R7 ident", d, 8'hB0);

    // R5: request only
    write_reg(8'h1A, 8'h04, "R5");
    check("R5 mode unchanged", ddc, 0);
    read_reg(8'h1A, d); check("R5 read pending", d, 8'h06);

    // R4: request and grant
    write_reg(8'h1A, 8'h06, "R4");
    check("R4 mode on", ddc, 1);

    // R5: request only while on keeps mode
    write_reg(8'h1A, 8'h04, "R5");
    check("R5 mode kept", ddc, 1);

    // R2: pointer byte is not written to the current register (0x1A)
    read_reg(8'h19, d); check("R8 reg19", d, 8'h00);
    bus_start();
    send_byte(AW, a); check("R2 addr ack", a, 1);
    send_byte(8'h00, a); check("R2 ptr ack", a, 1);
    bus_stop();
    check("R2 pointer byte not stored", ddc, 1);
    bus_start();
    send_byte(AR, a); check("R2 addr ack", a, 1);
    recv_byte(1'b1, d); check("R2 read ptr0", d, 8'h00);
    recv_byte(1'b0, d); check("R3 read ptr1", d, 8'h00);
    bus_stop();

    // R6: clear
    write_reg(8'h1A, 8'h01, "R6");
    check("R6 mode off", ddc, 0);
    read_reg(8'h1A, d); check("R6 read cleared", d, 8'h00);

    // R9/R3: write sweep over all addresses with mode on, then read sweep
    write_reg(8'h1A, 8'h06, "R4");
    bus_start();
    send_byte(AW, a); check("R9 addr ack", a, 1);
    send_byte(8'h00, a); check("R9 ptr ack", a, 1);
    for (int i = 0; i < 256; i++) begin
      send_byte(~8'(i), a);
      check("R9 data ack", a, 1);
    end
    bus_start();
    send_byte(AR, a); check("R12 restart ack", a, 1);
    for (int i = 0; i < 256; i++) begin
      recv_byte(i != 255, d);
      check((i == 8'h1A) ? "R5" : "R9", d, exp_reg(8'(i), 1'b1));
    end
    // R10: after the NACK further clocks see a released SDA
    for (int i = 0; i < 9; i++) begin
      xfer_bit(1'b1, v);
      check("R10 released", v, 1);
    end
    bus_stop();
    check("R9 mode kept", ddc, 1);

    // R11: reset while in pass-through
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset mode", ddc, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_start();
    send_byte(AR, a); check("R11 addr ack", a, 1);
    recv_byte(1'b0, d); check("R11 ptr reset", d, 8'h00);
    bus_stop();
    read_reg(8'h1A, d); check("R11 req cleared", d, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule